// File: doc/BRIEF.md
# Station Address RAM Image Writer

This block turns a 48-bit station address, given as twelve hex digits, into an eight-word image in a 16-bit adapter RAM. It starts from word 0. Each of the first six words carries one address byte in its upper half, and the most significant byte comes first. The lower half of every word is zero. The last two words hold a 16-bit checksum. The checksum adds the address's three 16-bit halfwords and drops any carry past bit 15. Its upper byte goes into word 6 and its lower byte into word 7, again in the upper half of each word.

A one-cycle start pulse loads the address into a register. The block then drives a RAM write port for eight consecutive cycles, one word per cycle, in ascending word order. The checksum is formed combinationally from the loaded address, so it is ready before the first write. A one-cycle done pulse follows the last write. While a sequence is running, the block ignores both the start input and any change on the address input.

For address 0001FAFE1093 the image is 0000 0100 FA00 FE00 1000 9300 0B00 9200.

Top module: `stn_image_writer`

## Requirements
- R1: While reset is asserted and after it is released with no start, ram_we and done are both 0.
- R2: A start seen while idle produces writes in the eight following cycles, one per cycle, with ram_addr stepping 0,1,...,7 and no gap.
- R3: Words 0 to 5 carry address bytes in bits 15:8, taken from stn_addr[47:40] for word 0 down to stn_addr[7:0] for word 5. Bits 7:0 are zero.
- R4: The checksum is (stn_addr[47:32] + stn_addr[31:16] + stn_addr[15:0]) mod 65536. Bits 15:8 of the checksum appear in word 6 bits 15:8, and bits 7:0 of the checksum appear in word 7 bits 15:8. The low bytes of both words are zero.
- R5: done is high for exactly one cycle, the cycle right after the word 7 write, and ram_we is 0 in that cycle.
- R6: A start that arrives during a write sequence has no effect. The sequence keeps its order and data, and no further writes follow the done pulse.
- R7: A start that arrives in the done cycle is accepted, and a new sequence for the new address begins on the next cycle.
- R8: The address is captured at start. Changes on stn_addr during a sequence do not alter the words written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to write the image |
| stn_addr | input | 48 | Station address, most significant hex digit in bits 47:44 |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 3 | RAM word address |
| ram_data | output | 16 | RAM write data |
| done | output | 1 | One-cycle pulse after the last word is written |

## Verification
The done pulse that closes one image and the acceptance of a new start can land in the same cycle. The bench provokes this by raising start on exactly the cycle in which it sees done high. It then requires that the next cycle already shows a write to word 0 carrying the new address's first byte, and that the whole second image is correct. A start raised in the middle of a sequence is the contrasting case: there the bench requires that the sequence is unchanged and that the write enable is idle after the done pulse.

// File: rtl/siw_pkg.sv
package siw_pkg;

    typedef enum logic {
        PH_IDLE  = 1'b0,
        PH_WRITE = 1'b1
    } siw_phase_e;

    localparam int unsigned SIW_BYTE_W = 8;

endpackage

// File: rtl/siw_csum.sv
module siw_csum #(
    parameter int unsigned NBYTES = 6,
    parameter int unsigned DW     = 16
) (
    input  logic [8*NBYTES-1:0] stn,
    output logic [DW-1:0]       sum
);
    localparam int unsigned NHALF = (8 * NBYTES) / DW;

    logic [DW-1:0] acc;

    always_comb begin
        acc = '0;
        for (int h = 0; h < NHALF; h++) begin
            acc = acc + stn[h*DW +: DW];
        end
    end

    assign sum = acc;

endmodule

// File: rtl/siw_word_mux.sv
module siw_word_mux #(
    parameter int unsigned NBYTES = 6,
    parameter int unsigned DW     = 16,
    parameter int unsigned AW     = 3
) (
    input  logic [AW-1:0]       idx,
    input  logic [8*NBYTES-1:0] stn,
    input  logic [DW-1:0]       sum,
    output logic [DW-1:0]       word
);
    import siw_pkg::*;

    localparam int unsigned BW       = SIW_BYTE_W;
    localparam int unsigned CS_WORDS = DW / BW;
    localparam int unsigned NWORDS   = NBYTES + CS_WORDS;

    logic [DW-1:0] words [NWORDS];

    for (genvar g = 0; g < NBYTES; g++) begin : g_stn
        assign words[g] = {stn[8*NBYTES-1-BW*g -: BW], {(DW-BW){1'b0}}};
    end

    for (genvar c = 0; c < CS_WORDS; c++) begin : g_cs
        assign words[NBYTES+c] = {sum[DW-1-BW*c -: BW], {(DW-BW){1'b0}}};
    end

    assign word = words[idx];

endmodule

// File: rtl/siw_seq.sv
module siw_seq #(
    parameter int unsigned NBYTES = 6,
    parameter int unsigned NWORDS = 8,
    parameter int unsigned AW     = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [8*NBYTES-1:0] stn_in,
    output logic                busy,
    output logic [AW-1:0]       idx,
    output logic                done,
    output logic [8*NBYTES-1:0] stn_hold
);
    import siw_pkg::*;

    localparam logic [AW-1:0] LAST_IDX = AW'(NWORDS - 1);

    typedef struct packed {
        siw_phase_e          phase;
        logic [AW-1:0]       idx;
        logic                done;
        logic [8*NBYTES-1:0] stn;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.phase = PH_WRITE;
                    st_d.idx   = '0;
                    st_d.stn   = stn_in;
                end
            end
            PH_WRITE: begin
                if (st_q.idx == LAST_IDX) begin
                    st_d.phase = PH_IDLE;
                    st_d.done  = 1'b1;
                end else begin
                    st_d.idx = AW'(st_q.idx + 1'b1);
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, idx: '0, done: 1'b0, stn: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy     = (st_q.phase == PH_WRITE);
    assign idx      = st_q.idx;
    assign done     = st_q.done;
    assign stn_hold = st_q.stn;

endmodule

// File: rtl/stn_image_writer.sv
module stn_image_writer #(
    parameter int unsigned NBYTES = 6,
    parameter int unsigned DW     = 16,
    parameter int unsigned AW     = $clog2(NBYTES + DW / 8)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [8*NBYTES-1:0] stn_addr,
    output logic                ram_we,
    output logic [AW-1:0]       ram_addr,
    output logic [DW-1:0]       ram_data,
    output logic                done
);
    localparam int unsigned NWORDS = NBYTES + DW / 8;

    logic [8*NBYTES-1:0] stn_q;
    logic [DW-1:0]       csum;
    logic [AW-1:0]       idx;
    logic                busy;

    siw_seq #(.NBYTES(NBYTES), .NWORDS(NWORDS), .AW(AW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .stn_in   (stn_addr),
        .busy     (busy),
        .idx      (idx),
        .done     (done),
        .stn_hold (stn_q)
    );

    siw_csum #(.NBYTES(NBYTES), .DW(DW)) u_csum (
        .stn (stn_q),
        .sum (csum)
    );

    siw_word_mux #(.NBYTES(NBYTES), .DW(DW), .AW(AW)) u_mux (
        .idx  (idx),
        .stn  (stn_q),
        .sum  (csum),
        .word (ram_data)
    );

    assign ram_we   = busy;
    assign ram_addr = idx;

endmodule

// File: rtl/siw_checker.sv
module siw_checker #(
    parameter int unsigned DW     = 16,
    parameter int unsigned AW     = 3,
    parameter int unsigned NWORDS = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          ram_we,
    input logic [AW-1:0] ram_addr,
    input logic [DW-1:0] ram_data,
    input logic          done
);
    localparam logic [AW-1:0] LAST = AW'(NWORDS - 1);

    p_first_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ram_we && start) |=> (ram_we && ram_addr == '0));

    p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && ram_addr != LAST) |=> (ram_we && ram_addr == AW'($past(ram_addr) + 1'b1)));

    p_low_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (ram_data[DW/2-1:0] == '0));

    p_done_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && ram_addr == LAST) |=> (done && !ram_we));

    p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_busy_start_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && ram_addr != LAST && start) |=> (ram_addr != '0));

endmodule

bind stn_image_writer siw_checker #(.DW(DW), .AW(AW), .NWORDS(NWORDS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .ram_we   (ram_we),
    .ram_addr (ram_addr),
    .ram_data (ram_data),
    .done     (done)
);

// File: tb/sim_stn_image_writer.sv
module sim_stn_image_writer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [47:0] stn_addr = '0;
    logic        ram_we;
    logic [2:0]  ram_addr;
    logic [15:0] ram_data;
    logic        done;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always #2 clk = ~clk;

    stn_image_writer u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .stn_addr (stn_addr),
        .ram_we   (ram_we),
        .ram_addr (ram_addr),
        .ram_data (ram_data),
        .done     (done)
    );

    localparam int NV = 6;
    localparam logic [47:0] VEC [NV] = '{
        48'h0001_FAFE_1093,
        48'hFFFF_FFFF_FFFF,
        48'h0000_0000_0000,
        48'h1234_5678_9ABC,
        48'h8000_8000_8000,
        48'hA5C3_0F1E_7D29
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_word(input logic [47:0] a, input int i);
        logic [15:0] s;
        s = a[47:32] + a[31:16] + a[15:0];
        if (i < 6)       return {a[47-8*i -: 8], 8'h00};
        else if (i == 6) return {s[15:8], 8'h00};
        else             return {s[7:0], 8'h00};
    endfunction

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 20000", cyc);
            finish_run();
        end
    end

    // Raises start for one edge; returns at the negedge where word 0 shows.
    task automatic kick(input logic [47:0] a, input bit wait_first);
        if (wait_first) @(negedge clk);
        start    = 1'b1;
        stn_addr = a;
        @(negedge clk);
        start    = 1'b0;
    endtask

    // Checks eight words and the done cycle. At word poke_at it drives
    // start (if poke_start) and a new stn_addr value.
    task automatic walk(input logic [47:0] a, input int poke_at,
                        input bit poke_start, input logic [47:0] poke_val);
        for (int i = 0; i < 8; i++) begin
            check("R2 we", 32'(ram_we), 32'd1);
            check("R2 addr", 32'(ram_addr), 32'(i));
            check((i < 6) ? "R3 data" : "R4 data", 32'(ram_data), 32'(exp_word(a, i)));
            if (i == poke_at) begin
                start    = poke_start;
                stn_addr = poke_val;
            end
            @(negedge clk);
            start = 1'b0;
        end
        check("R5 done high", 32'(done), 32'd1);
        check("R5 no write at done", 32'(ram_we), 32'd0);
    endtask

    initial begin
        // R1: reset state
        @(negedge clk);
        check("R1 we in reset", 32'(ram_we), 32'd0);
        check("R1 done in reset", 32'(done), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R1 we idle", 32'(ram_we), 32'd0);
        check("R1 done idle", 32'(done), 32'd0);

        // Table walk: R2 R3 R4 R5
        for (int v = 0; v < NV; v++) begin
            kick(VEC[v], 1'b1);
            walk(VEC[v], -1, 1'b0, 48'h0);
            @(negedge clk);
            check("R5 done single", 32'(done), 32'd0);
        end

        // R4: checksum literal for the worked example
        kick(48'h0001_FAFE_1093, 1'b1);
        for (int i = 0; i < 6; i++) @(negedge clk);
        check("R4 word6", 32'(ram_data), 32'h0B00);
        @(negedge clk);
        check("R4 word7", 32'(ram_data), 32'h9200);
        @(negedge clk);
        @(negedge clk);

        // R6: start mid-sequence ignored
        kick(48'h1111_2222_3333, 1'b1);
        walk(48'h1111_2222_3333, 3, 1'b1, 48'hDEAD_BEEF_0BAD);
        @(negedge clk);
        check("R6 no restart we", 32'(ram_we), 32'd0);
        check("R6 no restart done", 32'(done), 32'd0);

        // R8: address input changes without start during sequence
        kick(48'h0F0E_0D0C_0B0A, 1'b1);
        walk(48'h0F0E_0D0C_0B0A, 1, 1'b0, 48'h5555_AAAA_5555);
        @(negedge clk);

        // R7: start in the done cycle is accepted
        kick(48'hCAFE_0000_F00D, 1'b1);
        walk(48'hCAFE_0000_F00D, -1, 1'b0, 48'h0);
        kick(48'h0102_0304_0506, 1'b0);
        check("R7 back-to-back we", 32'(ram_we), 32'd1);
        walk(48'h0102_0304_0506, -1, 1'b0, 48'h0);
        @(negedge clk);
        check("R7 idle after second", 32'(ram_we), 32'd0);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule